// File: doc/BRIEF.md
# Accumulator and Multiplier-Quotient Arithmetic Unit

This unit performs the arithmetic of a 40-bit single-accumulator machine. Each operation reads the accumulator value, the multiplier-quotient register value and one memory operand, and produces new values for both registers. The surrounding sequencer fetches the operand, presents it together with the current register contents and an 8-bit operation code, and pulses a start strobe. It then waits for a one-cycle done pulse and writes the returned values back into its registers.

Addition, subtraction and single-bit shifts of the accumulator finish in one cycle. Signed multiplication leaves a double-length product split across the register pair. Signed division leaves the quotient in the multiplier-quotient register and the remainder in the accumulator. Both run as loops that retire one operand bit per clock. While a loop runs, the unit reports busy and ignores further start strobes. Division by zero finishes at once and raises an error flag.

Top module: `acmq_arith_unit`

## Requirements
- R1: Code 0x05 returns AC + M and code 0x07 returns AC + |M| in the accumulator output. Both wrap modulo 2^40, and |M| of the most negative value is that same value.
- R2: Code 0x06 returns AC - M and code 0x08 returns AC - |M| in the accumulator output, wrapping modulo 2^40.
- R3: For codes 0x05 to 0x08, 0x14 and 0x15, done is high in the cycle right after the clock edge that accepts start, and the MQ output equals the MQ input.
- R4: Code 0x14 shifts AC left one bit with a zero entering bit 0. Code 0x15 shifts AC right one bit and copies bit 39 into itself.
- R5: Code 0x0B forms the signed 80-bit product MQ x M. Bits 79..40 go to the AC output and bits 39..0 go to the MQ output.
- R6: Code 0x0C divides MQ by M as signed values. The quotient, truncated toward zero, goes to the MQ output, and the remainder, which carries the dividend's sign, goes to the AC output. The most negative value divided by -1 wraps to itself.
- R7: For multiply, and for divide with a nonzero M, busy is high and done is low from the accepting edge onward, and done rises on the 41st clock edge after the accepting edge.
- R8: Code 0x0C with M equal to zero raises done and div_err together in the cycle after the accepting edge, and returns AC and MQ unchanged. div_err is never high without done.
- R9: A start strobe that arrives while busy is high has no effect on the running result, its latency or the done pulses.
- R10: Any other operation code finishes like R3, returns AC and MQ unchanged and leaves div_err low.
- R11: After reset, ac_out and mq_out are zero and done, busy and div_err are low. ac_out and mq_out hold their values in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation selected by opcode |
| opcode | input | 8 | Operation code |
| operand | input | 40 | Memory operand M |
| ac_in | input | 40 | Current accumulator value |
| mq_in | input | 40 | Current multiplier-quotient value |
| done | output | 1 | One-cycle pulse: result valid |
| busy | output | 1 | Iterative operation in progress |
| div_err | output | 1 | Division by zero, pulsed with done |
| ac_out | output | 40 | New accumulator value |
| mq_out | output | 40 | New multiplier-quotient value |

## Verification
Multiply and divide are tried with random full-width operands and with small operands of both signs. Together these cover all four sign combinations, so a sign correction applied to the wrong register, or applied only to the magnitude, gives a wrong value. Directed cases cover the most negative value squared, the most negative value divided by -1, remainders of odd dividends with mixed signs, and a zero divisor, which separates the wrapping, truncation and error paths. The random single-cycle operations mix operands whose top bit is set with operands whose top bit is clear, so a missing absolute value or a shift that fills with the wrong bit shows up. A start strobe injected in the middle of a multiply shows whether the running loop can be disturbed.

// File: rtl/acmq_pkg.sv
package acmq_pkg;

    localparam int unsigned DEF_WORD_W = 40;
    localparam int unsigned OPC_W      = 8;

    localparam logic [OPC_W-1:0] OPC_ADD     = 8'h05;
    localparam logic [OPC_W-1:0] OPC_SUB     = 8'h06;
    localparam logic [OPC_W-1:0] OPC_ADD_ABS = 8'h07;
    localparam logic [OPC_W-1:0] OPC_SUB_ABS = 8'h08;
    localparam logic [OPC_W-1:0] OPC_MUL     = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_DIV     = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_SHL     = 8'h14;
    localparam logic [OPC_W-1:0] OPC_SHR     = 8'h15;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADD,
        K_SUB,
        K_SHL,
        K_SHR,
        K_MUL,
        K_DIV
    } op_kind_t;

    typedef struct packed {
        op_kind_t kind;
        logic     use_abs;
    } op_dec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FIN
    } seq_state_t;

    function automatic op_dec_t decode_op(logic [OPC_W-1:0] opc);
        op_dec_t d;
        d.kind    = K_NONE;
        d.use_abs = 1'b0;
        case (opc)
            OPC_ADD:     d.kind = K_ADD;
            OPC_ADD_ABS: begin d.kind = K_ADD; d.use_abs = 1'b1; end
            OPC_SUB:     d.kind = K_SUB;
            OPC_SUB_ABS: begin d.kind = K_SUB; d.use_abs = 1'b1; end
            OPC_MUL:     d.kind = K_MUL;
            OPC_DIV:     d.kind = K_DIV;
            OPC_SHL:     d.kind = K_SHL;
            OPC_SHR:     d.kind = K_SHR;
            default:     d.kind = K_NONE;
        endcase
        return d;
    endfunction

    function automatic logic is_iterative(op_kind_t k);
        return (k == K_MUL) || (k == K_DIV);
    endfunction

endpackage

// File: rtl/acmq_addsub.sv
module acmq_addsub
    import acmq_pkg::*;
#(
    parameter int unsigned W = DEF_WORD_W
) (
    input  op_dec_t        dec,
    input  logic [W-1:0]   ac,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   res
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] opnd_sel;

    always_comb begin
        if (dec.use_abs && opnd[W-1]) begin
            opnd_sel = ~opnd + ONE;
        end else begin
            opnd_sel = opnd;
        end
    end

    always_comb begin
        case (dec.kind)
            K_ADD:   res = ac + opnd_sel;
            K_SUB:   res = ac - opnd_sel;
            K_SHL:   res = {ac[W-2:0], 1'b0};
            K_SHR:   res = {ac[W-1], ac[W-1:1]};
            default: res = ac;
        endcase
    end

endmodule

// File: rtl/acmq_mul_core.sv
module acmq_mul_core
    import acmq_pkg::*;
#(
    parameter int unsigned W = DEF_WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [W-1:0]   prod_hi,
    output logic [W-1:0]   prod_lo
);
    localparam logic [W-1:0]   ONE  = W'(1);
    localparam logic [2*W-1:0] ONE2 = (2*W)'(1);

    logic [W-1:0] mcand_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;
    logic         neg_q;

    logic [W:0]     partial;
    logic [2*W-1:0] mag;
    logic [2*W-1:0] signed_prod;

    always_comb begin
        partial = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            mcand_q <= mcand_in[W-1] ? (~mcand_in + ONE) : mcand_in;
            lo_q    <= mplier_in[W-1] ? (~mplier_in + ONE) : mplier_in;
            hi_q    <= '0;
            neg_q   <= mcand_in[W-1] ^ mplier_in[W-1];
        end else if (step) begin
            hi_q <= partial[W:1];
            lo_q <= {partial[0], lo_q[W-1:1]};
        end
    end

    always_comb begin
        mag         = {hi_q, lo_q};
        signed_prod = neg_q ? (~mag + ONE2) : mag;
        prod_hi     = signed_prod[2*W-1:W];
        prod_lo     = signed_prod[W-1:0];
    end

endmodule

// File: rtl/acmq_div_core.sv
module acmq_div_core
    import acmq_pkg::*;
#(
    parameter int unsigned W = DEF_WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   dividend_in,
    input  logic [W-1:0]   divisor_in,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic         qneg_q;
    logic         rneg_q;

    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] rem_next;

    always_comb begin
        trial    = {rem_q, quo_q[W-1]};
        fits     = (trial >= {1'b0, dvs_q});
        rem_next = fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= dividend_in[W-1] ? (~dividend_in + ONE) : dividend_in;
            dvs_q  <= divisor_in[W-1] ? (~divisor_in + ONE) : divisor_in;
            qneg_q <= dividend_in[W-1] ^ divisor_in[W-1];
            rneg_q <= dividend_in[W-1];
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    always_comb begin
        quotient  = qneg_q ? (~quo_q + ONE) : quo_q;
        remainder = rneg_q ? (~rem_q + ONE) : rem_q;
    end

endmodule

// File: rtl/acmq_arith_unit.sv
module acmq_arith_unit
    import acmq_pkg::*;
#(
    parameter int unsigned W = DEF_WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [W-1:0]       operand,
    input  logic [W-1:0]       ac_in,
    input  logic [W-1:0]       mq_in,
    output logic               done,
    output logic               busy,
    output logic               div_err,
    output logic [W-1:0]       ac_out,
    output logic [W-1:0]       mq_out
);
    localparam int unsigned    CNT_W     = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    seq_state_t      state_q;
    op_kind_t        kind_q;
    logic [CNT_W-1:0] step_cnt_q;
    logic [W-1:0]    ac_q;
    logic [W-1:0]    mq_q;
    logic            done_q;
    logic            err_q;

    op_dec_t         dec;
    logic            accept;
    logic            opnd_zero;
    logic            go_iter;
    logic            mul_load;
    logic            div_load;
    logic            mul_step;
    logic            div_step;
    logic [W-1:0]    alu_res;
    logic [W-1:0]    prod_hi;
    logic [W-1:0]    prod_lo;
    logic [W-1:0]    quo;
    logic [W-1:0]    rem;

    always_comb begin
        dec       = decode_op(opcode);
        accept    = start && (state_q == S_IDLE);
        opnd_zero = (operand == '0);
        go_iter   = accept && is_iterative(dec.kind) &&
                    !((dec.kind == K_DIV) && opnd_zero);
        mul_load  = go_iter && (dec.kind == K_MUL);
        div_load  = go_iter && (dec.kind == K_DIV);
        mul_step  = (state_q == S_RUN) && (kind_q == K_MUL);
        div_step  = (state_q == S_RUN) && (kind_q == K_DIV);
    end

    acmq_addsub #(.W(W)) u_addsub (
        .dec  (dec),
        .ac   (ac_in),
        .opnd (operand),
        .res  (alu_res)
    );

    acmq_mul_core #(.W(W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (mul_load),
        .step      (mul_step),
        .mcand_in  (operand),
        .mplier_in (mq_in),
        .prod_hi   (prod_hi),
        .prod_lo   (prod_lo)
    );

    acmq_div_core #(.W(W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .load        (div_load),
        .step        (div_step),
        .dividend_in (mq_in),
        .divisor_in  (operand),
        .quotient    (quo),
        .remainder   (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            kind_q     <= K_NONE;
            step_cnt_q <= '0;
            ac_q       <= '0;
            mq_q       <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (go_iter) begin
                        state_q    <= S_RUN;
                        kind_q     <= dec.kind;
                        step_cnt_q <= '0;
                    end else if (accept) begin
                        done_q <= 1'b1;
                        mq_q   <= mq_in;
                        if (dec.kind == K_DIV) begin
                            err_q <= 1'b1;
                            ac_q  <= ac_in;
                        end else begin
                            ac_q  <= alu_res;
                        end
                    end
                end
                S_RUN: begin
                    step_cnt_q <= step_cnt_q + CNT_ONE;
                    if (step_cnt_q == LAST_STEP) begin
                        state_q <= S_FIN;
                    end
                end
                S_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                    if (kind_q == K_MUL) begin
                        ac_q <= prod_hi;
                        mq_q <= prod_lo;
                    end else begin
                        ac_q <= rem;
                        mq_q <= quo;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign div_err = err_q;
    assign busy    = (state_q != S_IDLE);
    assign ac_out  = ac_q;
    assign mq_out  = mq_q;

endmodule

// File: rtl/acmq_arith_chk.sv
module acmq_arith_chk
    import acmq_pkg::*;
#(
    parameter int unsigned W = DEF_WORD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [OPC_W-1:0] opcode,
    input logic [W-1:0]     operand,
    input logic [W-1:0]     ac_in,
    input logic [W-1:0]     mq_in,
    input logic             done,
    input logic             busy,
    input logic             div_err,
    input logic [W-1:0]     ac_out,
    input logic [W-1:0]     mq_out
);
    op_dec_t d;
    logic    acc_single;
    logic    acc_iter;
    logic    acc_divzero;

    always_comb begin
        d           = decode_op(opcode);
        acc_single  = start && !busy && !is_iterative(d.kind);
        acc_iter    = start && !busy && ((d.kind == K_MUL) ||
                      ((d.kind == K_DIV) && (operand != '0)));
        acc_divzero = start && !busy && (d.kind == K_DIV) && (operand == '0);
    end

    logic        pending_q;
    int unsigned lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            lat_q     <= 0;
        end else if (acc_iter) begin
            pending_q <= 1'b1;
            lat_q     <= 0;
        end else if (pending_q) begin
            if (done) pending_q <= 1'b0;
            lat_q <= lat_q + 1;
        end
    end

    p_single_done_r3: assert property (@(posedge clk) disable iff (rst)
        acc_single |=> done && !busy && !div_err);

    p_mq_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_single && (d.kind != K_NONE)) |=> (mq_out == $past(mq_in)));

    p_shl_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == OPC_SHL) |=>
        (ac_out == {$past(ac_in[W-2:0]), 1'b0}));

    p_shr_sign_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == OPC_SHR) |=>
        (ac_out == {$past(ac_in[W-1]), $past(ac_in[W-1:1])}));

    p_iter_busy_r7: assert property (@(posedge clk) disable iff (rst)
        acc_iter |=> busy && !done);

    p_no_done_when_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    p_iter_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (pending_q && done) |-> (lat_q == W + 1));

    p_divzero_r8: assert property (@(posedge clk) disable iff (rst)
        acc_divzero |=> done && div_err &&
        (ac_out == $past(ac_in)) && (mq_out == $past(mq_in)));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        div_err |-> done);

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_single && d.kind == K_NONE) |=>
        (ac_out == $past(ac_in)) && (mq_out == $past(mq_in)));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ac_out) && $stable(mq_out)));

endmodule

bind acmq_arith_unit acmq_arith_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opcode  (opcode),
    .operand (operand),
    .ac_in   (ac_in),
    .mq_in   (mq_in),
    .done    (done),
    .busy    (busy),
    .div_err (div_err),
    .ac_out  (ac_out),
    .mq_out  (mq_out)
);

// File: tb/tb_acmq_arith_unit.sv
`timescale 1ns/1ps
module tb_acmq_arith_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  opcode;
    logic [39:0] operand;
    logic [39:0] ac_in;
    logic [39:0] mq_in;
    logic        done;
    logic        busy;
    logic        div_err;
    logic [39:0] ac_out;
    logic [39:0] mq_out;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    localparam logic [39:0] MAXP = 40'h7F_FFFF_FFFF;
    localparam logic [39:0] MINN = 40'h80_0000_0000;
    localparam logic [39:0] NEG1 = 40'hFF_FFFF_FFFF;

    acmq_arith_unit dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .operand(operand), .ac_in(ac_in), .mq_in(mq_in),
        .done(done), .busy(busy), .div_err(div_err),
        .ac_out(ac_out), .mq_out(mq_out)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    function automatic logic [39:0] absw(logic [39:0] v);
        return v[39] ? (~v + 40'd1) : v;
    endfunction

    // Expected values from the requirements.
    task automatic model(input logic [7:0] opc, input logic [39:0] m, a, q,
                         output logic [39:0] e_ac, output logic [39:0] e_mq,
                         output logic e_err, output int e_lat);
        logic signed [79:0] pa, pb, pp;
        longint dd, dv, qq, rr;
        e_ac = a; e_mq = q; e_err = 1'b0; e_lat = 0;
        case (opc)
            8'h05: e_ac = a + m;
            8'h07: e_ac = a + absw(m);
            8'h06: e_ac = a - m;
            8'h08: e_ac = a - absw(m);
            8'h14: e_ac = {a[38:0], 1'b0};
            8'h15: e_ac = {a[39], a[39:1]};
            8'h0B: begin
                pa = {{40{q[39]}}, q};
                pb = {{40{m[39]}}, m};
                pp = pa * pb;
                e_ac = pp[79:40]; e_mq = pp[39:0]; e_lat = 41;
            end
            8'h0C: begin
                if (m == 40'd0) begin
                    e_err = 1'b1;
                end else begin
                    dd = longint'({{24{q[39]}}, q});
                    dv = longint'({{24{m[39]}}, m});
                    qq = dd / dv;
                    rr = dd % dv;
                    e_mq = qq[39:0]; e_ac = rr[39:0]; e_lat = 41;
                end
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [39:0] m, a, q,
                          output int lat);
        @(negedge clk);
        opcode = opc; operand = m; ac_in = a; mq_in = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_op(input string tag, input logic [7:0] opc,
                            input logic [39:0] m, a, q);
        logic [39:0] e_ac, e_mq;
        logic e_err;
        int e_lat, lat;
        model(opc, m, a, q, e_ac, e_mq, e_err, e_lat);
        run_op(opc, m, a, q, lat);
        n_vec++;
        if (ac_out !== e_ac || mq_out !== e_mq || div_err !== e_err || lat != e_lat) begin
            n_fail++;
            $display("FAIL %s op=%h: actual ac=%h mq=%h err=%b lat=%0d expected ac=%h mq=%h err=%b lat=%0d",
                     tag, opc, ac_out, mq_out, div_err, lat, e_ac, e_mq, e_err, e_lat);
        end
    endtask

    function automatic logic [39:0] rnd40();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        case ($urandom_range(0, 3))
            0:       return {{32{t[7]}}, t[7:0]};
            1:       return {t[39], {20{t[39]}}, t[18:0]};
            default: return t[39:0];
        endcase
    endfunction

    initial begin
        logic [7:0] ops [10];
        logic [39:0] e_ac, e_mq, hold_ac, hold_mq;
        logic e_err;
        int e_lat, lat;
        bit extra;

        ops = '{8'h05, 8'h07, 8'h06, 8'h08, 8'h0B, 8'h0C, 8'h14, 8'h15, 8'h00, 8'h21};
        void'($urandom(32'd20240611));
        start = 0; opcode = 0; operand = 0; ac_in = 0; mq_in = 0;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        n_vec++;
        if (ac_out !== 40'd0 || mq_out !== 40'd0 || done !== 1'b0 || busy !== 1'b0 || div_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: actual ac=%h mq=%h done=%b busy=%b err=%b expected all zero",
                     ac_out, mq_out, done, busy, div_err);
        end

        // R1 / R2 directed
        check_op("R1 add wrap", 8'h05, 40'd1, MAXP, 40'd7);
        check_op("R1 add abs of min", 8'h07, MINN, 40'd5, 40'd3);
        check_op("R1 add abs neg", 8'h07, NEG1 - 40'd9, 40'd100, 40'd0);
        check_op("R2 sub wrap", 8'h06, 40'd1, MINN, 40'd9);
        check_op("R2 sub abs", 8'h08, NEG1, 40'd0, 40'h12);
        // R3 / R4 directed
        check_op("R4 shl msb set", 8'h14, 40'd0, 40'hC0_0000_0001, 40'd1);
        check_op("R4 shr negative", 8'h15, 40'd0, 40'h80_0000_0003, 40'd2);
        check_op("R4 shr positive", 8'h15, 40'd0, 40'h40_0000_0003, 40'd2);
        // R5 directed
        check_op("R5 mul min*min", 8'h0B, MINN, 40'd0, MINN);
        check_op("R5 mul -1*-1", 8'h0B, NEG1, 40'd0, NEG1);
        check_op("R5 mul min*1", 8'h0B, 40'd1, 40'd0, MINN);
        check_op("R5 mul max*-3", 8'h0B, NEG1 - 40'd2, 40'd0, MAXP);
        // R6 directed
        check_op("R6 div min/-1", 8'h0C, NEG1, 40'd0, MINN);
        check_op("R6 div 7/-2", 8'h0C, NEG1 - 40'd1, 40'd0, 40'd7);
        check_op("R6 div -7/2", 8'h0C, 40'd2, 40'd0, NEG1 - 40'd6);
        check_op("R6 div small/large", 8'h0C, 40'd1000, 40'd0, 40'd999);
        // R8 directed
        check_op("R8 div by zero", 8'h0C, 40'd0, 40'h12_3456_789A, 40'h0F_EDCB_A987);
        // R10 directed
        check_op("R10 undefined 00", 8'h00, 40'd55, 40'hAA_AAAA_AAAA, 40'h55_5555_5555);
        check_op("R10 undefined 21", 8'h21, 40'd55, 40'h01_0203_0405, 40'h06_0708_090A);

        // R11 hold while done low
        hold_ac = ac_out; hold_mq = mq_out;
        @(negedge clk);
        ac_in = ~ac_in; mq_in = ~mq_in; operand = 40'd3; opcode = 8'h05;
        repeat (3) @(negedge clk);
        n_vec++;
        if (ac_out !== hold_ac || mq_out !== hold_mq || done !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 hold: actual ac=%h mq=%h done=%b expected ac=%h mq=%h done=0",
                     ac_out, mq_out, done, hold_ac, hold_mq);
        end

        // R9 start while busy ignored, R7 busy during the loop
        model(8'h0B, 40'h00_1234_5678, 40'd0, NEG1 - 40'd77, e_ac, e_mq, e_err, e_lat);
        @(negedge clk);
        opcode = 8'h0B; operand = 40'h00_1234_5678; ac_in = 0; mq_in = NEG1 - 40'd77; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (5) begin @(negedge clk); lat++; end
        n_vec++;
        if (busy !== 1'b1 || done !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 busy mid-loop: actual busy=%b done=%b expected busy=1 done=0", busy, done);
        end
        opcode = 8'h05; operand = 40'd9; ac_in = 40'd1; mq_in = 40'd2; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        n_vec++;
        if (ac_out !== e_ac || mq_out !== e_mq || lat != 41) begin
            n_fail++;
            $display("FAIL R9 ignored start: actual ac=%h mq=%h lat=%0d expected ac=%h mq=%h lat=41",
                     ac_out, mq_out, lat, e_ac, e_mq);
        end
        extra = 1'b0;
        repeat (4) begin @(negedge clk); if (done) extra = 1'b1; end
        n_vec++;
        if (extra) begin
            n_fail++;
            $display("FAIL R9 extra done: actual extra pulse=1 expected 0");
        end

        // Random mix covering R1..R8, R10
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = ops[$urandom_range(0, 9)];
            check_op("R1-R10 random", op, rnd40(), rnd40(), rnd40());
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule